// File: doc/BRIEF.md
# Remote Upgrade Boot Supervisor

This block chooses which configuration image a device boots and forces a return to the factory image when the running or loading application misbehaves. Software programs a 39-bit control word through a parallel write port. That word packs an application boot address field, a watchdog timeout field and three option bits. While the factory image runs, the boot address output is zero. When the factory image launches the application (`app_boot`), the output becomes the programmed address, padded with two zero bits. The block then times the load against a programmable expected length.

During application load, it watches for an early or invalid configuration-done, a CRC error and an external error. Once the application runs, it watches the external error and an optional user watchdog. The watchdog is a 29-bit down-counter. Its reload value is the timeout field followed by a fixed 17-bit pattern of 8, and a kick pulse reloads it. Any failure produces a one-cycle reconfiguration request and a return to the factory address. It also sets a sticky cause bit and records which image was active in a status word that software clears by writing ones.

Top module: `rsu_supervisor`

## Requirements
- R1: After reset, `reconfig_req` is 0, `boot_addr` is 0, `status` is 0, and `ctrl_q` is 39'h40_0000_0000: bit 38 is 1 and every other bit is 0.
- R2: A `cfg_we` cycle loads `cfg_wdata` into `ctrl_q` on the next edge. Bits 38 and 34 are reserved: they keep the values 1 and 0 whatever is written. Bit 37 enables the early check, bit 36 selects the internal startup oscillator, bit 35 enables the watchdog, bits 33:12 hold the address field and bits 11:0 hold the timeout field.
- R3: While the application is loading or running, `boot_addr` equals {ctrl_q[33:12], 2'b00}. While the factory image runs, `boot_addr` is 0.
- R4: An `app_boot` pulse sampled while the factory image runs starts an application load. An `app_boot` pulse during a load is ignored and does not restart the load-time count.
- R5: With bit 37 set, a `cfg_done` sampled on the k-th edge after the boot edge is early when k ≤ `load_len`, and it triggers with cause bit 3. When k > `load_len`, the application starts running. With bit 37 clear, `cfg_done` always starts the application.
- R6: With bit 37 set, `image_bad` sampled during a load triggers with cause bit 3.
- R7: `crc_err` sampled during a load triggers with cause bit 1. `crc_err` is ignored while the application runs or the factory image runs.
- R8: `ext_err` sampled during a load or a run triggers with cause bit 2. `ext_err` is ignored while the factory image runs.
- R9: With bit 35 set, entering the run state loads the counter with R = {ctrl_q[11:0], 17'd8}. A `wd_kick` during the run reloads R. If the counter was loaded on edge e and not reloaded, the trigger with cause bit 0 occurs on edge e+R+1. With bit 35 clear, no timeout occurs.
- R10: On a trigger, `reconfig_req` is 1 for exactly one cycle, the factory image becomes active (so `boot_addr` is 0), and the watchdog stops. Status bit 4 is set to 1 if the trigger happened during a run and 0 if it happened during a load.
- R11: Status bits 3:0 are sticky. A `stat_clr_we` cycle clears every status bit whose `stat_clr_mask` bit is 1. A cause that sets a bit in the same cycle wins over the clear.
- R12: `osc_int_sel` follows `ctrl_q[36]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 39 | Control word write data |
| ctrl_q | output | 39 | Current control word |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr_mask | input | 5 | Status bits to clear (ones clear) |
| status | output | 5 | {image_was_app, early, ext, crc, watchdog} |
| app_boot | input | 1 | Factory image launches the application |
| load_len | input | 16 | Expected load time in cycles |
| cfg_done | input | 1 | Configuration done |
| image_bad | input | 1 | Image at boot address judged invalid |
| crc_err | input | 1 | CRC error during load |
| ext_err | input | 1 | External device error |
| wd_kick | input | 1 | Watchdog kick |
| reconfig_req | output | 1 | One-cycle reconfiguration request |
| boot_addr | output | 24 | Selected boot byte address |
| osc_int_sel | output | 1 | Internal startup oscillator select |

## Verification
The bench drives `cfg_done` on both sides of the `load_len` boundary (k = 10 and k = 11 with a length of 10). This separates an early done from a valid one, and a repeated `app_boot` pulse placed mid-load shows whether the count restarts. Each trigger source is raised both inside and outside the state where it counts. A CRC error while running and an external error in the factory image must produce no request, which tells the state gating apart from a plain OR of inputs. The watchdog runs unkicked, kicked repeatedly, and disabled, and the request cycle is predicted from the last reload. A clear that coincides with a new cause shows whether the set or the clear takes priority.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  typedef enum logic [1:0] {
    ST_FACTORY = 2'd0,
    ST_LOAD    = 2'd1,
    ST_RUN     = 2'd2
  } rsu_state_e;

  localparam int STAT_W  = 5;
  localparam int STAT_IMG = 4;

  // Packed so that the struct maps onto status bits [3:0].
  typedef struct packed {
    logic early;
    logic ext;
    logic crc;
    logic wd;
  } rsu_cause_t;
endpackage

// File: rtl/rsu_ctrl_reg.sv
module rsu_ctrl_reg #(
  parameter int ADDR_FW = 22,
  parameter int TMO_FW  = 12,
  localparam int CTRL_W = ADDR_FW + TMO_FW + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q
);
  localparam int RSV_LO = ADDR_FW + TMO_FW;
  localparam int WDEN   = RSV_LO + 1;
  localparam int EARLY  = RSV_LO + 3;
  localparam int RSV_HI = RSV_LO + 4;
  localparam logic [CTRL_W-1:0] RST_VAL = {1'b1, {(CTRL_W-1){1'b0}}};

  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = wdata;
    ctrl_d[RSV_LO] = 1'b0;
    ctrl_d[RSV_HI] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= RST_VAL;
    else if (we) ctrl_q <= ctrl_d;
  end

  assert_opt_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ctrl_q[EARLY:WDEN] == $past(wdata[EARLY:WDEN]));
endmodule

// File: rtl/rsu_wdog.sv
module rsu_wdog #(
  parameter int TMO_FW  = 12,
  parameter int PAD_W   = 17,
  parameter int PAD_VAL = 8,
  localparam int CNT_W  = TMO_FW + PAD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMO_FW-1:0] tmo,
  input  logic              start,
  input  logic              active,
  input  logic              kick,
  output logic              expire
);
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    reload = {tmo, PAD_W'(PAD_VAL)};
    expire = active && (cnt_q == '0) && !kick;
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (start || (active && kick)) begin
      cnt_en = 1'b1;
      cnt_d  = reload;
    end else if (active && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_kick_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && kick) |=> cnt_q == $past(reload));
  assert_count_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !kick && !start && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/rsu_seq.sv
module rsu_seq
  import rsu_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             app_boot,
  input  logic             cfg_done,
  input  logic             image_bad,
  input  logic             crc_err,
  input  logic             ext_err,
  input  logic             early_en,
  input  logic [LEN_W-1:0] load_len,
  input  logic             wd_expire,
  output rsu_state_e       state_q,
  output rsu_cause_t       cause,
  output logic             trig,
  output logic             run_start,
  output logic             reconfig_req
);
  rsu_state_e       state_d;
  logic [LEN_W-1:0] ld_cnt_q, ld_cnt_d;
  logic             ld_cnt_en;
  logic             in_load, in_app;

  always_comb begin
    in_load     = (state_q == ST_LOAD);
    in_app      = in_load || (state_q == ST_RUN);
    cause.early = in_load && early_en &&
                  (image_bad || (cfg_done && (ld_cnt_q < load_len)));
    cause.crc   = in_load && crc_err;
    cause.ext   = in_app && ext_err;
    cause.wd    = wd_expire;
    trig        = |cause;
    run_start   = in_load && cfg_done && !trig;

    state_d = state_q;
    if (trig) state_d = ST_FACTORY;
    else begin
      unique case (state_q)
        ST_FACTORY: if (app_boot) state_d = ST_LOAD;
        ST_LOAD:    if (cfg_done) state_d = ST_RUN;
        default:    state_d = state_q;
      endcase
    end

    ld_cnt_en = 1'b0;
    ld_cnt_d  = ld_cnt_q;
    if ((state_q == ST_FACTORY) && app_boot) begin
      ld_cnt_en = 1'b1;
      ld_cnt_d  = '0;
    end else if (in_load && (ld_cnt_q != '1)) begin
      ld_cnt_en = 1'b1;
      ld_cnt_d  = ld_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_FACTORY;
      reconfig_req <= 1'b0;
      ld_cnt_q     <= '0;
    end else begin
      state_q      <= state_d;
      reconfig_req <= trig;
      if (ld_cnt_en) ld_cnt_q <= ld_cnt_d;
    end
  end

  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig_req |=> !reconfig_req);
  assert_load_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_LOAD) |-> $past(app_boot));
endmodule

// File: rtl/rsu_status.sv
module rsu_status
  import rsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  rsu_cause_t        cause,
  input  logic              img_app,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_mask,
  output logic [STAT_W-1:0] stat_q
);
  logic [STAT_W-1:0] stat_d;
  logic [STAT_W-1:0] clr_eff;

  always_comb begin
    clr_eff             = clr_we ? clr_mask : '0;
    stat_d[STAT_IMG-1:0] = (stat_q[STAT_IMG-1:0] & ~clr_eff[STAT_IMG-1:0]) | cause;
    if (trig)                   stat_d[STAT_IMG] = img_app;
    else if (clr_eff[STAT_IMG]) stat_d[STAT_IMG] = 1'b0;
    else                        stat_d[STAT_IMG] = stat_q[STAT_IMG];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> (stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0]));
  assert_cause_logged_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> stat_q[3:0] != '0);
endmodule

// File: rtl/rsu_supervisor.sv
module rsu_supervisor
  import rsu_pkg::*;
#(
  parameter int ADDR_FW    = 22,
  parameter int TMO_FW     = 12,
  parameter int WD_PAD_W   = 17,
  parameter int WD_PAD_VAL = 8,
  parameter int LEN_W      = 16,
  localparam int CTRL_W    = ADDR_FW + TMO_FW + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  input  logic              stat_clr_we,
  input  logic [STAT_W-1:0] stat_clr_mask,
  output logic [STAT_W-1:0] status,
  input  logic              app_boot,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              cfg_done,
  input  logic              image_bad,
  input  logic              crc_err,
  input  logic              ext_err,
  input  logic              wd_kick,
  output logic              reconfig_req,
  output logic [ADDR_FW+1:0] boot_addr,
  output logic              osc_int_sel
);
  localparam int ADDR_LSB = TMO_FW;
  localparam int WDEN     = ADDR_FW + TMO_FW + 1;
  localparam int OSC      = WDEN + 1;
  localparam int EARLY    = WDEN + 2;

  rsu_state_e state;
  rsu_cause_t cause;
  logic       trig, run_start, wd_expire, wd_active;

  rsu_ctrl_reg #(.ADDR_FW(ADDR_FW), .TMO_FW(TMO_FW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .ctrl_q(ctrl_q)
  );

  rsu_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .app_boot(app_boot), .cfg_done(cfg_done),
    .image_bad(image_bad), .crc_err(crc_err), .ext_err(ext_err),
    .early_en(ctrl_q[EARLY]), .load_len(load_len), .wd_expire(wd_expire),
    .state_q(state), .cause(cause), .trig(trig), .run_start(run_start),
    .reconfig_req(reconfig_req)
  );

  assign wd_active = (state == ST_RUN) && ctrl_q[WDEN];

  rsu_wdog #(.TMO_FW(TMO_FW), .PAD_W(WD_PAD_W), .PAD_VAL(WD_PAD_VAL)) u_wdog (
    .clk(clk), .rst_n(rst_n), .tmo(ctrl_q[TMO_FW-1:0]), .start(run_start),
    .active(wd_active), .kick(wd_kick), .expire(wd_expire)
  );

  rsu_status u_stat (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cause(cause),
    .img_app(state == ST_RUN), .clr_we(stat_clr_we), .clr_mask(stat_clr_mask),
    .stat_q(status)
  );

  always_comb begin
    boot_addr   = (state == ST_FACTORY) ? '0 : {ctrl_q[ADDR_LSB +: ADDR_FW], 2'b00};
    osc_int_sel = ctrl_q[OSC];
  end

  assert_wd_trigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> (reconfig_req && status[0]));
  assert_factory_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig_req |-> boot_addr == '0);
endmodule

// File: tb/rsu_supervisor_tb.sv
module rsu_supervisor_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, stat_clr_we, app_boot, cfg_done, image_bad, crc_err, ext_err, wd_kick;
  logic [38:0] cfg_wdata, ctrl_q;
  logic [4:0]  stat_clr_mask, status;
  logic [15:0] load_len;
  logic        reconfig_req, osc_int_sel;
  logic [23:0] boot_addr;

  int checks = 0, errors = 0, cyc = 0;
  bit prev_req = 0;

  typedef struct { int cyc; logic [4:0] st; string tag; } exp_t;
  exp_t sb[$];

  localparam logic [21:0] ADDR = 22'h2A_5A5A;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rsu_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .ctrl_q(ctrl_q),
    .stat_clr_we(stat_clr_we), .stat_clr_mask(stat_clr_mask), .status(status),
    .app_boot(app_boot), .load_len(load_len), .cfg_done(cfg_done),
    .image_bad(image_bad), .crc_err(crc_err), .ext_err(ext_err), .wd_kick(wd_kick),
    .reconfig_req(reconfig_req), .boot_addr(boot_addr), .osc_int_sel(osc_int_sel)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [38:0] mk(bit e, bit o, bit w, logic [21:0] a, logic [11:0] t);
    return {1'b0, e, o, w, 1'b0, a, t};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [38:0] d);
    cfg_wdata = d; cfg_we = 1'b1; step(1); cfg_we = 1'b0;
  endtask

  task automatic clr_all();
    stat_clr_mask = 5'h1f; stat_clr_we = 1'b1; step(1); stat_clr_we = 1'b0;
    chk(status, 5'h00, "R11 clear all");
  endtask

  // Cause driven now is sampled at the next edge; the request appears then.
  task automatic expect_req(input logic [4:0] st, input string tag);
    exp_t e;
    e.cyc = cyc + 1; e.st = st; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic boot();
    app_boot = 1'b1; step(1); app_boot = 1'b0;
  endtask

  task automatic pulse_done();
    cfg_done = 1'b1; step(1); cfg_done = 1'b0;
  endtask

  // Monitor: pops expected requests and compares cycle and status.
  always @(negedge clk) begin
    if (rst_n) begin
      if (reconfig_req) begin
        if (prev_req) begin
          checks++; errors++;
          $display("FAIL R10 request longer than one cycle: actual 1 expected 0");
        end
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7/R8 unexpected request at cycle %0d: actual 1 expected 0", cyc);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(cyc, e.cyc, {e.tag, " request cycle"});
          chk(status, e.st, {e.tag, " status"});
          chk(boot_addr, 24'h0, "R10 factory address on request");
        end
      end
      prev_req = reconfig_req;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; stat_clr_we = 0; app_boot = 0; cfg_done = 0;
    image_bad = 0; crc_err = 0; ext_err = 0; wd_kick = 0;
    cfg_wdata = '0; stat_clr_mask = '0; load_len = 16'd10;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(reconfig_req, 0, "R1 req");
    chk(boot_addr, 0, "R1 boot_addr");
    chk(status, 0, "R1 status");
    chk(ctrl_q, 39'h40_0000_0000, "R1 ctrl_q");

    // R2 reserved bits, R12 oscillator select
    wr_ctrl(39'h7F_FFFF_FFFF);
    chk(ctrl_q, 39'h7B_FFFF_FFFF, "R2 reserved bits");
    chk(osc_int_sel, 1, "R12 osc select");
    wr_ctrl(mk(1, 0, 0, ADDR, 12'h0));
    chk(ctrl_q, {1'b1, mk(1, 0, 0, ADDR, 12'h0)} & 39'h7F_FFFF_FFFF | 39'h40_0000_0000, "R2 write");
    chk(osc_int_sel, 0, "R12 osc clear");

    // R3/R5: early done at k = 10 (load_len = 10)
    chk(boot_addr, 0, "R3 factory address");
    boot();
    chk(boot_addr, {ADDR, 2'b00}, "R3 application address");
    step(9);
    expect_req(5'b01000, "R5 early done k=10");
    pulse_done();
    step(2);
    chk(boot_addr, 0, "R10 back to factory");
    clr_all();

    // R4/R5: k = 11 is valid; a repeated boot mid-load is ignored
    boot();
    step(4); app_boot = 1'b1; step(1); app_boot = 1'b0;
    step(5);
    pulse_done();
    step(5);
    chk(boot_addr, {ADDR, 2'b00}, "R3 address while running R4 R5");
    expect_req(5'b10100, "R8 ext error while running");
    ext_err = 1'b1; step(1); ext_err = 1'b0;
    step(2);
    clr_all();

    // R5 disabled early check; R7 CRC ignored while running
    wr_ctrl(mk(0, 0, 0, ADDR, 12'h0));
    boot();
    pulse_done();
    step(3);
    crc_err = 1'b1; step(1); crc_err = 1'b0;
    step(3);
    chk(status, 0, "R7 crc ignored while running");
    expect_req(5'b10100, "R5 disabled check then R8 exit");
    ext_err = 1'b1; step(1); ext_err = 1'b0;
    step(2);
    clr_all();

    // R6 invalid image
    wr_ctrl(mk(1, 0, 0, ADDR, 12'h0));
    boot(); step(2);
    expect_req(5'b01000, "R6 image bad");
    image_bad = 1'b1; step(1); image_bad = 1'b0;
    step(2);
    clr_all();

    // R7 CRC during load; R8 ext error in factory ignored
    boot(); step(3);
    expect_req(5'b00010, "R7 crc during load");
    crc_err = 1'b1; step(1); crc_err = 1'b0;
    step(2);
    clr_all();
    ext_err = 1'b1; step(2); ext_err = 1'b0;
    step(3);
    chk(status, 0, "R8 ext ignored in factory");
    chk(boot_addr, 0, "R8 still factory");

    // R9 watchdog, unkicked: R = 8, request 10 cycles after done driven
    wr_ctrl(mk(0, 0, 1, ADDR, 12'h0));
    boot();
    begin
      exp_t e;
      e.cyc = cyc + 10; e.st = 5'b10001; e.tag = "R9 watchdog timeout";
      sb.push_back(e);
    end
    pulse_done();
    step(12);
    clr_all();

    // R9 kicks keep it alive; timeout measured from last kick
    boot();
    pulse_done();
    for (int i = 0; i < 4; i++) begin
      step(5);
      wd_kick = 1'b1; step(1); wd_kick = 1'b0;
    end
    step(4);
    begin
      exp_t e;
      e.cyc = cyc + 10; e.st = 5'b10001; e.tag = "R9 timeout after kicks";
      sb.push_back(e);
    end
    wd_kick = 1'b1; step(1); wd_kick = 1'b0;
    step(12);
    clr_all();

    // R9 watchdog disabled
    wr_ctrl(mk(0, 0, 0, ADDR, 12'h0));
    boot(); pulse_done();
    step(30);
    chk(status, 0, "R9 no timeout when disabled");
    expect_req(5'b10100, "R9 disabled then R8 exit");
    ext_err = 1'b1; step(1); ext_err = 1'b0;
    step(2);
    clr_all();

    // R11 set wins over clear in same cycle, then partial clear
    boot(); pulse_done(); step(2);
    expect_req(5'b10100, "R11 set wins over clear");
    ext_err = 1'b1; stat_clr_mask = 5'b00100; stat_clr_we = 1'b1;
    step(1);
    ext_err = 1'b0; stat_clr_we = 1'b0;
    step(1);
    chk(status, 5'b10100, "R11 status after set and clear");
    stat_clr_mask = 5'b00100; stat_clr_we = 1'b1; step(1); stat_clr_we = 1'b0;
    chk(status, 5'b10000, "R11 partial clear");

    step(5);
    chk(sb.size(), 0, "R10 all expected requests seen");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule